// File: doc/BRIEF.md
# Branch-and-Link Execution Unit

This execute-stage unit carries out a subroutine-call instruction that comes in two forms: a short register-register form and a longer register-indexed form. On the cycle an instruction issues, the unit takes several inputs: the two register fields, the read data of the register named by the second field, the effective address from the address adder, the current condition code and program mask, the updated instruction address, and a flag that marks execution as the target of an execute instruction.

One cycle later it does two things in the same cycle. It drives a register-file write of a 32-bit link word into the register named by the first field. It also reports whether the instruction address is to be redirected, and to what target. The target comes from values sampled at issue, so it is fixed before the link word reaches the register file. If the same register is named as both link and target, the branch still goes to that register's old contents. The unit does not change the condition code and raises no exceptions.

Top module: `bal_exec_unit`

## Requirements
- R1: After reset, wr_en_o and br_taken_o are 0 and wr_data_o, wr_idx_o and br_target_o are all zero.
- R2: One cycle after an issue, wr_en_o is 1 and wr_idx_o equals the r1_i of that issue. wr_en_o is 0 in any cycle that does not follow an issue.
- R3: The link word written has the length code in bits 31:30, the condition code in bits 29:28, the program mask in bits 27:24, and the 24-bit updated instruction address in bits 23:0. All of these are the values present at issue.
- R4: When not under execute, the length code is 1 for the register-register form (fmt_i = 0) and 2 for the register-indexed form (fmt_i = 1).
- R5: When under_exec_i is 1 at issue, the length code is 2 in both forms.
- R6: In register-register form with r2_i nonzero, br_taken_o is 1 one cycle after issue and br_target_o equals bits 23:0 of r2_data_i at issue.
- R7: In register-register form with r2_i equal to zero, br_taken_o stays 0, but the link word is still written.
- R8: In register-indexed form, br_taken_o is 1 and br_target_o equals ea_i at issue, whatever the value of r2_i, including zero.
- R9: When r1_i equals r2_i, the branch target is taken from the register contents before the link write.
- R10: br_taken_o is only ever 1 in a cycle in which wr_en_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Instruction issues this cycle |
| fmt_i | input | 1 | Form: 0 register-register, 1 register-indexed |
| r1_i | input | 4 | Link register field |
| r2_i | input | 4 | Second register field (target or index) |
| r2_data_i | input | 32 | Register file read data for r2_i |
| ea_i | input | 24 | Effective address from the address adder |
| cc_i | input | 2 | Current condition code |
| pmask_i | input | 4 | Current program mask |
| next_ia_i | input | 24 | Updated instruction address |
| under_exec_i | input | 1 | Instruction runs as target of an execute instruction |
| wr_en_o | output | 1 | Register write enable |
| wr_idx_o | output | 4 | Register write index |
| wr_data_o | output | 32 | Link word |
| br_taken_o | output | 1 | Redirect the instruction address |
| br_target_o | output | 24 | Branch target address |

## Verification
The bench builds the unit with its default parameters: 16 registers and a 24-bit address. That configuration is small enough to sweep every pairing of link and target register under both forms, with the under-execute flag both clear and set. The sweep therefore covers every same-register case and every zero-field case. A bench-side register file model feeds back each link write, so later targets read contents that the unit itself produced.

// File: rtl/bal_pkg.sv
package bal_pkg;

    localparam int IA_W   = 24;
    localparam int WORD_W = 32;

    typedef enum logic {
        FMT_RR = 1'b0,
        FMT_RX = 1'b1
    } bal_fmt_e;

    localparam logic [1:0] ILC_SHORT = 2'd1;
    localparam logic [1:0] ILC_LONG  = 2'd2;

    typedef struct packed {
        logic [1:0]      ilc;
        logic [1:0]      cc;
        logic [3:0]      pmask;
        logic [IA_W-1:0] ia;
    } link_word_t;

    typedef struct packed {
        logic            taken;
        logic [IA_W-1:0] target;
    } branch_t;

    function automatic logic [1:0] length_code(bal_fmt_e fmt, logic under_exec);
        if (under_exec || fmt == FMT_RX)
            return ILC_LONG;
        return ILC_SHORT;
    endfunction

endpackage

// File: rtl/bal_link_gen.sv
module bal_link_gen
    import bal_pkg::*;
(
    input  bal_fmt_e        fmt,
    input  logic            under_exec,
    input  logic [1:0]      cc,
    input  logic [3:0]      pmask,
    input  logic [IA_W-1:0] next_ia,
    output link_word_t      link
);

    always_comb begin
        link.ilc   = length_code(fmt, under_exec);
        link.cc    = cc;
        link.pmask = pmask;
        link.ia    = next_ia;
    end

endmodule

// File: rtl/bal_target_sel.sv
module bal_target_sel
    import bal_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  bal_fmt_e          fmt,
    input  logic [IDX_W-1:0]  r2,
    input  logic [WORD_W-1:0] r2_data,
    input  logic [IA_W-1:0]   ea,
    output branch_t           br
);

    always_comb begin
        if (fmt == FMT_RX) begin
            br.taken  = 1'b1;
            br.target = ea;
        end else begin
            br.taken  = (r2 != '0);
            br.target = r2_data[IA_W-1:0];
        end
    end

endmodule

// File: rtl/bal_exec_unit.sv
module bal_exec_unit
    import bal_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_i,
    input  logic              fmt_i,
    input  logic [IDX_W-1:0]  r1_i,
    input  logic [IDX_W-1:0]  r2_i,
    input  logic [WORD_W-1:0] r2_data_i,
    input  logic [IA_W-1:0]   ea_i,
    input  logic [1:0]        cc_i,
    input  logic [3:0]        pmask_i,
    input  logic [IA_W-1:0]   next_ia_i,
    input  logic              under_exec_i,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              br_taken_o,
    output logic [IA_W-1:0]   br_target_o
);

    bal_fmt_e   fmt;
    link_word_t link_d;
    branch_t    br_d;

    assign fmt = bal_fmt_e'(fmt_i);

    bal_link_gen u_link (
        .fmt        (fmt),
        .under_exec (under_exec_i),
        .cc         (cc_i),
        .pmask      (pmask_i),
        .next_ia    (next_ia_i),
        .link       (link_d)
    );

    bal_target_sel #(.IDX_W(IDX_W)) u_tgt (
        .fmt     (fmt),
        .r2      (r2_i),
        .r2_data (r2_data_i),
        .ea      (ea_i),
        .br      (br_d)
    );

    // Target and link are both sampled at issue; the write and redirect
    // leave together one cycle later, so the target never sees the write.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_o     <= 1'b0;
            wr_idx_o    <= '0;
            wr_data_o   <= '0;
            br_taken_o  <= 1'b0;
            br_target_o <= '0;
        end else begin
            wr_en_o    <= issue_i;
            br_taken_o <= issue_i && br_d.taken;
            if (issue_i) begin
                wr_idx_o    <= r1_i;
                wr_data_o   <= link_d;
                br_target_o <= br_d.target;
            end
        end
    end

    p_wr_follows_issue_r2: assert property (@(posedge clk) disable iff (rst)
        issue_i |=> (wr_en_o && wr_idx_o == $past(r1_i)));

    p_no_spurious_wr_r2: assert property (@(posedge clk) disable iff (rst)
        !issue_i |=> !wr_en_o);

    p_link_fields_r3: assert property (@(posedge clk) disable iff (rst)
        issue_i |=> (wr_data_o[29:28] == $past(cc_i) &&
                     wr_data_o[27:24] == $past(pmask_i) &&
                     wr_data_o[23:0]  == $past(next_ia_i)));

    p_ilc_exec_r5: assert property (@(posedge clk) disable iff (rst)
        (issue_i && under_exec_i) |=> wr_data_o[31:30] == ILC_LONG);

    p_rr_zero_no_branch_r7: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !fmt_i && r2_i == '0) |=> (!br_taken_o && wr_en_o));

    p_rx_branch_r8: assert property (@(posedge clk) disable iff (rst)
        (issue_i && fmt_i) |=> (br_taken_o && br_target_o == $past(ea_i)));

    p_taken_with_wr_r10: assert property (@(posedge clk) disable iff (rst)
        br_taken_o |-> wr_en_o);

endmodule

// File: tb/bal_exec_unit_tb.sv
module bal_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue_i;
    logic        fmt_i;
    logic [3:0]  r1_i;
    logic [3:0]  r2_i;
    logic [31:0] r2_data_i;
    logic [23:0] ea_i;
    logic [1:0]  cc_i;
    logic [3:0]  pmask_i;
    logic [23:0] next_ia_i;
    logic        under_exec_i;
    logic        wr_en_o;
    logic [3:0]  wr_idx_o;
    logic [31:0] wr_data_o;
    logic        br_taken_o;
    logic [23:0] br_target_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    logic [31:0] rf [16];

    always #5 clk = ~clk;

    bal_exec_unit u_dut (
        .clk(clk), .rst(rst), .issue_i(issue_i), .fmt_i(fmt_i),
        .r1_i(r1_i), .r2_i(r2_i), .r2_data_i(r2_data_i), .ea_i(ea_i),
        .cc_i(cc_i), .pmask_i(pmask_i), .next_ia_i(next_ia_i),
        .under_exec_i(under_exec_i), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
        .wr_data_o(wr_data_o), .br_taken_o(br_taken_o), .br_target_o(br_target_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            summary();
        end
    end

    task automatic run_one(int i, logic f, logic ux, logic [3:0] a, logic [3:0] b);
        logic [31:0] old_b;
        logic [1:0]  ilc;
        logic [31:0] link;
        logic        taken;
        logic [23:0] tgt;
        @(negedge clk);
        issue_i      = 1'b1;
        fmt_i        = f;
        under_exec_i = ux;
        r1_i         = a;
        r2_i         = b;
        cc_i         = 2'(i);
        pmask_i      = 4'(i * 7);
        next_ia_i    = 24'(i * 24'h001357 + 24'h002468) & 24'hFFFFFE;
        ea_i         = 24'(i * 24'h0B0B01);
        old_b        = rf[b];
        r2_data_i    = old_b;
        ilc   = (ux || f) ? 2'd2 : 2'd1;
        link  = {ilc, cc_i, pmask_i, next_ia_i};
        taken = f || (b != 4'd0);
        tgt   = f ? ea_i : old_b[23:0];
        @(negedge clk);
        issue_i   = 1'b0;
        r2_data_i = 32'hDEAD_BEEF;
        ea_i      = ~ea_i;
        chk("R2 wr_en", {31'd0, wr_en_o}, 32'd1);
        chk("R2 wr_idx", {28'd0, wr_idx_o}, {28'd0, a});
        if (ux) chk("R5 link", wr_data_o, link);
        else    chk("R3/R4 link", wr_data_o, link);
        if (!f && b == 4'd0) chk("R7 taken", {31'd0, br_taken_o}, 32'd0);
        else if (f)          chk("R8 taken", {31'd0, br_taken_o}, 32'd1);
        else                 chk("R6 taken", {31'd0, br_taken_o}, 32'd1);
        if (taken) begin
            if (a == b) chk("R9 target", {8'd0, br_target_o}, {8'd0, tgt});
            else if (f) chk("R8 target", {8'd0, br_target_o}, {8'd0, tgt});
            else        chk("R6 target", {8'd0, br_target_o}, {8'd0, tgt});
        end
        chk("R10 taken needs wr", {31'd0, br_taken_o && !wr_en_o}, 32'd0);
        if (wr_en_o) rf[wr_idx_o] = wr_data_o;
        if (a == b) chk("R9 reg after write", rf[a], link);
        @(negedge clk);
        chk("R2 idle wr_en", {31'd0, wr_en_o}, 32'd0);
        chk("R10 idle taken", {31'd0, br_taken_o}, 32'd0);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) rf[k] = 32'hA500_0000 ^ (k * 32'h0107_0B13);
        rst = 1'b1; issue_i = 1'b0; fmt_i = 1'b0; r1_i = '0; r2_i = '0;
        r2_data_i = '0; ea_i = '0; cc_i = '0; pmask_i = '0; next_ia_i = '0;
        under_exec_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 wr_en", {31'd0, wr_en_o}, 32'd0);
        chk("R1 taken", {31'd0, br_taken_o}, 32'd0);
        chk("R1 wr_data", wr_data_o, 32'd0);
        chk("R1 wr_idx", {28'd0, wr_idx_o}, 32'd0);
        chk("R1 target", {8'd0, br_target_o}, 32'd0);
        rst = 1'b0;
        for (int f = 0; f < 2; f++)
            for (int ux = 0; ux < 2; ux++)
                for (int a = 0; a < 16; a++)
                    for (int b = 0; b < 16; b++)
                        run_one(f * 512 + ux * 256 + a * 16 + b + 1,
                                1'(f), 1'(ux), 4'(a), 4'(b));
        summary();
    end

endmodule